// File: doc/BRIEF.md
# Two-Step Packed BCD Adder

This block adds or subtracts packed decimal operands that are one to four bytes wide, in two clocked instructions. The first instruction is an ordinary binary add (B + A) or subtract (B − A) on the selected low bytes. In the same cycle the block works out one decimal carry or borrow per four-bit digit. These carries do not change that cycle's result. They are kept in an 8-bit digit-carry register, one bit per nibble.

The second instruction is a correction step. It takes the previous binary result on B and adds or subtracts a correction word. That word has the value 6 in every nibble whose stored carry is set. Because the digit carries are held in state between the two instructions, an interrupt can be taken between the binary step and the correction step without losing anything.

The C, Z, N and V flags and the digit carries form the block's status. Status is written at each clock edge unless the hold input is high.

Top module: `bcd_twostep_alu`

## Requirements
- R1: `width_sel` selects how many low bytes take part in the operation, counted from bit 0: 00 selects 4 bytes, 01 selects 1 byte, 10 selects 2 bytes and 11 selects 3 bytes.
- R2: With `op`=00 the selected bytes of `y` are the binary sum B + A, and with `op`=01 they are the binary difference B − A. No decimal adjustment is applied in either case.
- R3: After an `op`=00 or `op`=01 clock edge with hold low, `digit_carry[i]` holds the decimal carry (add) or decimal borrow (subtract) out of nibble i. Nibble i is bits 4i+3..4i. The carry chain starts at nibble 0 with no carry in, and every nibble above the selected width reads 0.
- R4: With `op`=10 the selected bytes of `y` are B plus a correction word. The correction word has 0x6 in each selected nibble whose stored digit carry is 1, and 0 in every other nibble. A has no effect.
- R5: With `op`=11 the selected bytes of `y` are B minus the same correction word. A has no effect.
- R6: The correction operations (`op`=10 and `op`=11) leave `digit_carry` unchanged.
- R7: The unselected high bytes of `y` are equal to the same bytes of B.
- R8: After a clock edge, `flag_c` holds the carry out of the selected top bit. For the subtract operations (`op`=01 and `op`=11) it holds the inverted carry (a borrow) when `borrow_mode` is 1. The add operations always store the true carry.
- R9: After a clock edge, `flag_v` holds the XOR of the carry into and the carry out of the selected top bit (bit 7, 15, 23 or 31).
- R10: After a clock edge, `flag_z` is 1 when all selected bytes of `y` are zero, and `flag_n` holds the selected top bit of `y`.
- R11: While `hold` is 1, a clock edge leaves the flags and `digit_carry` unchanged.
- R12: An active-low reset clears all flags and `digit_carry` to 0.
- R13: For valid BCD operands, a binary step followed by the matching correction step gives, on the selected bytes, the decimal sum (B + A) mod 10^d or the decimal difference (B − A) mod 10^d, where d is the number of selected digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | 32 | Source operand |
| b | input | 32 | Destination operand, and the source of the unselected bytes |
| width_sel | input | 2 | Byte-width code |
| op | input | 2 | 00 binary add, 01 binary subtract, 10 sum correction, 11 difference correction |
| hold | input | 1 | Freezes the status register |
| borrow_mode | input | 1 | Stores subtract carries as borrows |
| y | output | 32 | Combinational result |
| flag_c | output | 1 | Stored carry/borrow |
| flag_z | output | 1 | Stored zero flag |
| flag_n | output | 1 | Stored negative flag |
| flag_v | output | 1 | Stored overflow flag |
| digit_carry | output | 8 | Stored per-nibble decimal carries |

## Verification
The assertions assume that every input holds a known value at each clock edge. They also assume that `hold` is sampled as a level on the same edge as the operation it blocks. None of the assertions relies on the digits being valid BCD.

The decimal meaning of the result depends on valid BCD, so the stimulus draws each selected digit from 0 to 9 and fills only the unselected bytes with arbitrary bits. It also feeds the result of each binary step back on B for the correction step that follows, which is the operating pattern the correction logic assumes.

// File: rtl/bcd_twostep_alu.sv
module bcd_twostep_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic [1:0]  width_sel,
  input  logic [1:0]  op,
  input  logic        hold,
  input  logic        borrow_mode,
  output logic [31:0] y,
  output logic        flag_c,
  output logic        flag_z,
  output logic        flag_n,
  output logic        flag_v,
  output logic [7:0]  digit_carry
);
  localparam int NBYTES = 4;
  localparam int NDIG   = 2 * NBYTES;

  logic [2:0]  nbytes;
  logic [5:0]  top;
  logic [4:0]  msb;
  logic [31:0] sel_mask;
  logic [7:0]  dig_mask;
  logic [31:0] corr, opnd, opnd_x, b_sel;
  logic [32:0] sum33;
  logic        is_sub, is_fix, cout, cin_msb;
  logic [7:0]  dc;
  logic [7:0]  nc_q;
  logic        c_q, z_q, n_q, v_q;

  assign is_sub = op[0];
  assign is_fix = op[1];
  assign nbytes = (width_sel == 2'b00) ? 3'd4 : {1'b0, width_sel};
  assign top    = {nbytes, 3'b000};
  assign msb    = 5'(top - 6'd1);

  always_comb begin
    for (int k = 0; k < NBYTES; k++) begin
      sel_mask[8*k +: 8] = (3'(k) < nbytes) ? 8'hFF : 8'h00;
      dig_mask[2*k +: 2] = (3'(k) < nbytes) ? 2'b11 : 2'b00;
    end
  end

  always_comb begin
    for (int i = 0; i < NDIG; i++)
      corr[4*i +: 4] = (nc_q[i] && dig_mask[i]) ? 4'h6 : 4'h0;
  end

  assign b_sel  = b & sel_mask;
  assign opnd   = is_fix ? corr : (a & sel_mask);
  assign opnd_x = is_sub ? (~opnd & sel_mask) : opnd;
  assign sum33  = {1'b0, b_sel} + {1'b0, opnd_x} + {32'd0, is_sub};

  assign cout    = sum33[top];
  assign cin_msb = sum33[msb] ^ b_sel[msb] ^ opnd_x[msb];
  assign y       = (sum33[31:0] & sel_mask) | (b & ~sel_mask);

  always_comb begin
    logic       chain, gen, prop;
    logic [3:0] ad, bd;
    logic [4:0] s5;
    chain = 1'b0;
    for (int i = 0; i < NDIG; i++) begin
      ad = a[4*i +: 4];
      bd = b[4*i +: 4];
      s5 = {1'b0, ad} + {1'b0, bd};
      if (is_sub) begin
        gen  = bd < ad;
        prop = bd == ad;
      end else begin
        gen  = s5 > 5'd9;
        prop = s5 == 5'd9;
      end
      dc[i] = dig_mask[i] & (gen | (prop & chain));
      chain = dc[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nc_q <= '0;
      c_q  <= 1'b0;
      z_q  <= 1'b0;
      n_q  <= 1'b0;
      v_q  <= 1'b0;
    end else if (!hold) begin
      c_q <= (is_sub && borrow_mode) ? ~cout : cout;
      z_q <= (y & sel_mask) == 32'd0;
      n_q <= y[msb];
      v_q <= cin_msb ^ cout;
      if (!is_fix) nc_q <= dc;
    end
  end

  assign flag_c      = c_q;
  assign flag_z      = z_q;
  assign flag_n      = n_q;
  assign flag_v      = v_q;
  assign digit_carry = nc_q;

  // R11
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable({nc_q, c_q, z_q, n_q, v_q}));

  // R6
  fix_keeps_carries_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fix && !hold) |=> $stable(digit_carry));

  // R3
  upper_carries_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_fix && !hold && width_sel == 2'b01) |=> (digit_carry[7:2] == 6'd0));

  // R7
  unsel_from_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (width_sel == 2'b10) |-> (y[31:16] == b[31:16]));

  // R10
  zero_not_negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z |-> !flag_n);
endmodule

// File: tb/bcd_twostep_alu_test.sv
`timescale 1ns/1ps
module bcd_twostep_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [1:0]  width_sel = '0, op = '0;
  logic        hold = 1'b0, borrow_mode = 1'b0;
  logic [31:0] y;
  logic        flag_c, flag_z, flag_n, flag_v;
  logic [7:0]  digit_carry;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  bcd_twostep_alu uut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .width_sel(width_sel), .op(op),
    .hold(hold), .borrow_mode(borrow_mode), .y(y), .flag_c(flag_c),
    .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v), .digit_carry(digit_carry)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] w);
    return (w == 2'b00) ? 4 : int'(w);
  endfunction

  function automatic logic [31:0] wmask(input logic [1:0] w);
    longint unsigned m;
    m = (64'd1 << (8 * nb(w))) - 1;
    return m[31:0];
  endfunction

  function automatic void alu_ref(input logic sub, input logic [31:0] bv, input logic [31:0] ov,
                                  input logic [1:0] w, input logic bm,
                                  output logic [31:0] ye, output logic ce, output logic ze,
                                  output logic ne, output logic ve);
    longint unsigned m, bb, oo, r;
    int wb;
    logic car, sb, so, sr;
    wb = 8 * nb(w);
    m  = (64'd1 << wb) - 1;
    bb = {32'd0, bv} & m;
    oo = {32'd0, ov} & m;
    if (!sub) begin
      r   = bb + oo;
      car = r[wb];
      r   = r & m;
    end else begin
      r   = (bb - oo) & m;
      car = bb >= oo;
    end
    sb = bb[wb-1];
    so = oo[wb-1];
    sr = r[wb-1];
    ve = sub ? ((sb != so) && (sr != sb)) : ((sb == so) && (sr != sb));
    ce = (sub && bm) ? !car : car;
    ze = (r == 0);
    ne = sr;
    ye = r[31:0] | (bv & ~m[31:0]);
  endfunction

  function automatic logic [7:0] dec_carries(input logic sub, input logic [31:0] av,
                                             input logic [31:0] bv, input logic [1:0] w);
    logic [7:0] r;
    int d, t;
    r = '0;
    d = 0;
    for (int i = 0; i < 2 * nb(w); i++) begin
      if (sub) begin
        t = int'(bv[4*i +: 4]) - int'(av[4*i +: 4]) - d;
        d = (t < 0) ? 1 : 0;
      end else begin
        t = int'(bv[4*i +: 4]) + int'(av[4*i +: 4]) + d;
        d = (t > 9) ? 1 : 0;
      end
      r[i] = d[0];
    end
    return r;
  endfunction

  function automatic logic [31:0] corr_word(input logic [7:0] nc, input logic [1:0] w);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 2 * nb(w); i++)
      if (nc[i]) r[4*i +: 4] = 4'h6;
    return r;
  endfunction

  function automatic longint bcd_val(input logic [31:0] v, input logic [1:0] w);
    longint s;
    s = 0;
    for (int i = 2 * nb(w) - 1; i >= 0; i--) s = s * 10 + longint'(v[4*i +: 4]);
    return s;
  endfunction

  function automatic logic [31:0] to_bcd(input longint x, input logic [1:0] w);
    logic [31:0] r;
    longint v;
    r = '0;
    v = x;
    for (int i = 0; i < 2 * nb(w); i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic logic [31:0] rand_bcd(input logic [1:0] w);
    logic [31:0] r;
    r = $urandom;
    for (int i = 0; i < 2 * nb(w); i++) r[4*i +: 4] = 4'($urandom % 10);
    return r;
  endfunction

  task automatic step(input logic [1:0] o, input logic [31:0] av, input logic [31:0] bv,
                      input logic [1:0] w, input logic h, input logic bm, output logic [31:0] yv);
    @(negedge clk);
    op = o; a = av; b = bv; width_sel = w; hold = h; borrow_mode = bm;
    #5 yv = y;
    @(posedge clk);
    #1;
  endtask

  task automatic check_flags(input string tag, input logic ce, input logic ze,
                             input logic ne, input logic ve);
    chk(flag_c == ce, {tag, " R8 carry"}, flag_c, ce);
    chk(flag_v == ve, {tag, " R9 overflow"}, flag_v, ve);
    chk(flag_z == ze, {tag, " R10 zero"}, flag_z, ze);
    chk(flag_n == ne, {tag, " R10 negative"}, flag_n, ne);
  endtask

  task automatic do_pair(input logic sub, input logic [31:0] av, input logic [31:0] bv,
                         input logic [1:0] w, input logic bm);
    logic [31:0] y1, y2, ye, cw, dexp, m;
    logic ce, ze, ne, ve;
    logic [7:0] nce;
    longint k, va, vb, res;
    m = wmask(w);
    step({1'b0, sub}, av, bv, w, 1'b0, bm, y1);
    alu_ref(sub, bv, av, w, bm, ye, ce, ze, ne, ve);
    chk(y1 == ye, "R2 R1 R7 binary step y", y1, ye);
    check_flags("binary", ce, ze, ne, ve);
    nce = dec_carries(sub, av, bv, w);
    chk(digit_carry == nce, "R3 digit carries", digit_carry, nce);
    cw = corr_word(nce, w);
    step({1'b1, sub}, $urandom, y1, w, 1'b0, bm, y2);
    alu_ref(sub, y1, cw, w, bm, ye, ce, ze, ne, ve);
    chk(y2 == ye, sub ? "R5 diff correction y" : "R4 sum correction y", y2, ye);
    check_flags("correction", ce, ze, ne, ve);
    chk(digit_carry == nce, "R6 carries kept", digit_carry, nce);
    k = 1;
    for (int i = 0; i < 2 * nb(w); i++) k = k * 10;
    va = bcd_val(av, w);
    vb = bcd_val(bv, w);
    res = sub ? (vb - va + k) % k : (vb + va) % k;
    dexp = (to_bcd(res, w) & m) | (bv & ~m);
    chk(y2 == dexp, "R13 decimal result", y2, dexp);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] yv, ye, held_nc;
    logic ce, ze, ne, ve;
    logic [3:0] held_flags;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1;
    chk({flag_c, flag_z, flag_n, flag_v} == 4'b0, "R12 reset flags", {flag_c, flag_z, flag_n, flag_v}, 0);
    chk(digit_carry == 8'd0, "R12 reset carries", digit_carry, 0);
    @(negedge clk);
    rst_n = 1'b1;

    do_pair(1'b0, 32'h00000001, 32'h99999999, 2'b00, 1'b0);
    do_pair(1'b1, 32'hDEAD0001, 32'hBEEF0000, 2'b10, 1'b1);
    do_pair(1'b0, 32'hFFFFFF01, 32'hA5A5A599, 2'b01, 1'b1);
    do_pair(1'b1, 32'h00000099, 32'h00000000, 2'b01, 1'b0);
    do_pair(1'b0, 32'h00123456, 32'h77987654, 2'b11, 1'b0);

    step(2'b00, 32'h00000055, 32'h00000055, 2'b01, 1'b0, 1'b1, yv);
    chk(flag_c == 1'b0, "R8 add ignores borrow mode", flag_c, 0);
    step(2'b01, 32'h00000056, 32'h00000055, 2'b01, 1'b0, 1'b1, yv);
    chk(flag_c == 1'b1, "R8 subtract borrow stored", flag_c, 1);
    step(2'b00, 32'h00000040, 32'h00000040, 2'b01, 1'b0, 1'b0, yv);
    chk(flag_v == 1'b1, "R9 overflow 0x40+0x40", flag_v, 1);
    chk(flag_n == 1'b1, "R10 negative bit 7", flag_n, 1);

    step(2'b00, 32'h00000009, 32'h00000009, 2'b00, 1'b0, 1'b0, yv);
    held_nc = {24'd0, digit_carry};
    held_flags = {flag_c, flag_z, flag_n, flag_v};
    step(2'b01, 32'h99999999, 32'h00000000, 2'b00, 1'b1, 1'b1, yv);
    chk(digit_carry == held_nc[7:0], "R11 hold carries", digit_carry, held_nc);
    chk({flag_c, flag_z, flag_n, flag_v} == held_flags, "R11 hold flags",
        {flag_c, flag_z, flag_n, flag_v}, held_flags);
    step(2'b10, 32'h12345678, 32'h00000012, 2'b00, 1'b0, 1'b0, yv);
    alu_ref(1'b0, 32'h00000012, corr_word(held_nc[7:0], 2'b00), 2'b00, 1'b0, ye, ce, ze, ne, ve);
    chk(yv == ye, "R4 correction after hold ignores A", yv, ye);

    for (int n = 0; n < 60; n++) begin
      logic [1:0] w;
      w = 2'($urandom % 4);
      do_pair(1'($urandom), rand_bcd(w), rand_bcd(w), w, 1'($urandom));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule